// File: doc/BRIEF.md
# Interrupt Status and Mode Controller

This block gathers single-cycle event pulses from a digital audio transceiver into two 8-bit status registers. Each defined status bit has its own sensitivity. It can latch on a rising edge or on a falling edge of its source, and it then holds until software reads its register. In level mode it instead tracks the source directly. An enable register for each status register decides which bits may raise the interrupt. The combined interrupt drives one pin, which can be formatted as active-high, as active-low, or as an active-low open-drain output with a separate output enable.

Software reaches the status, enable and mode registers through a simple register port. The port has a 7-bit address, a write strobe and a read strobe. Read data is combinational from the address. A read strobe on a status register clears that register's edge-latched bits at the next clock edge. The pin style comes in as a 2-bit input, because the field that holds it lives in another control register.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset, every status, enable and mode register reads 0x00 and the interrupt is inactive.
- R2: With mode bits hi/lo = 0/0, a status bit sets on the clock edge that first samples its source high after a low sample. A source that stays high does not set the bit again after a clear.
- R3: With mode bits hi/lo = 0/1, a status bit sets only when its source goes from high to low. A low-to-high change leaves it at 0.
- R4: With the mode hi bit = 1 (level), a status bit equals its source as sampled at the previous clock edge, and reading the register does not clear it.
- R5: An edge-latched status bit holds until its register is read. The read returns the set value and clears the bit at that clock edge. An edge that arrives in the same cycle as the read leaves the bit set.
- R6: The register map is: status A 0x07, status B 0x08, enable A 0x09, mode A hi 0x0A, mode A lo 0x0B, enable B 0x0C, mode B hi 0x0D, mode B lo 0x0E. Status registers ignore writes, and every other address reads 0x00.
- R7: Status A defines only bits 7, 6, 2, 1 and 0 (mask 0xC7), and status B defines only bits 3, 2 and 1 (mask 0x0E). Undefined bits read 0, ignore writes in the enable and mode registers, and ignore events.
- R8: An enable bit of 1 lets its status bit reach the interrupt, and 0 blocks it. A blocked status bit still latches and reads back.
- R9: The interrupt is active while any enabled status bit in either register is set.
- R10: With pin style 00, irq_pin_o equals the active interrupt and irq_oe_o is 1.
- R11: With pin style 01, irq_pin_o is the inverse of the active interrupt and irq_oe_o is 1.
- R12: With pin style 10 or 11 (open drain), irq_pin_o is always 0 and irq_oe_o is 1 only while the interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a_i | input | 8 | Event sources for status register A |
| evt_b_i | input | 8 | Event sources for status register B |
| reg_addr_i | input | 7 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; on a status address it clears edge-latched bits |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| pin_style_i | input | 2 | Pin style: 00 high, 01 low, 10/11 open drain |
| irq_pin_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench first walks a table of writes and readbacks over every mapped and several unmapped addresses. This catches a design that stores undefined bits, lets status registers take writes, or aliases unused addresses. Directed tests then check the following cases:

- A source held high after a clear. A design that re-arms on level would set the bit again.
- A rising change on a falling-mode bit, which a design that confuses the two modes would latch.
- A read of a level-mode bit, which a design that applies clear-on-read to every mode would wrongly zero.
- An edge that lands in the same cycle as a read. A design that lets the clear win would lose the event.
- A blocked bit that must still latch.
- An interrupt raised only from the second register.
- Every pin style, both with the interrupt active and with it idle. This catches an inverted polarity, or an open-drain output that drives high.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 7;

    localparam logic [REG_W-1:0] STAT_A_DEFINED = 8'hC7;
    localparam logic [REG_W-1:0] STAT_B_DEFINED = 8'h0E;

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 7'h07;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 7'h08;
    localparam logic [ADDR_W-1:0] ADR_EN_A   = 7'h09;
    localparam logic [ADDR_W-1:0] ADR_HI_A   = 7'h0A;
    localparam logic [ADDR_W-1:0] ADR_LO_A   = 7'h0B;
    localparam logic [ADDR_W-1:0] ADR_EN_B   = 7'h0C;
    localparam logic [ADDR_W-1:0] ADR_HI_B   = 7'h0D;
    localparam logic [ADDR_W-1:0] ADR_LO_B   = 7'h0E;

    typedef enum logic [1:0] {
        PIN_HIGH   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_OD     = 2'b10,
        PIN_OD_ALT = 2'b11
    } pin_style_e;

    typedef enum logic [1:0] {
        SENSE_RISE  = 2'b00,
        SENSE_FALL  = 2'b01,
        SENSE_LEVEL = 2'b10
    } sense_e;

    typedef struct packed {
        logic [REG_W-1:0] enable;
        logic [REG_W-1:0] mode_hi;
        logic [REG_W-1:0] mode_lo;
    } bank_cfg_t;

    typedef struct packed {
        logic level;
        logic oe;
    } pin_drv_t;

    function automatic sense_e sense_of(input logic hi, input logic lo);
        if (hi)
            return SENSE_LEVEL;
        else if (lo)
            return SENSE_FALL;
        return SENSE_RISE;
    endfunction

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
    import irq_stat_pkg::*;
#(
    parameter logic [REG_W-1:0] DEFINED = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src_i,
    input  bank_cfg_t        cfg_i,
    input  logic             clr_i,
    output logic [REG_W-1:0] stat_o,
    output logic             hit_o
);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (DEFINED[i]) begin : g_live
            logic   prev_q;
            logic   stat_q;
            sense_e sense;
            logic   edge_hit;

            always_comb begin
                sense = sense_of(cfg_i.mode_hi[i], cfg_i.mode_lo[i]);
                case (sense)
                    SENSE_RISE: edge_hit = src_i[i] & ~prev_q;
                    SENSE_FALL: edge_hit = ~src_i[i] & prev_q;
                    default:    edge_hit = 1'b0;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    stat_q <= 1'b0;
                end else begin
                    prev_q <= src_i[i];
                    if (sense == SENSE_LEVEL)
                        stat_q <= src_i[i];
                    else if (edge_hit)
                        stat_q <= 1'b1;
                    else if (clr_i)
                        stat_q <= 1'b0;
                end
            end

            assign stat_o[i] = stat_q;

            // R2: a rising source in rising mode sets the bit
            p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
                (!cfg_i.mode_hi[i] && !cfg_i.mode_lo[i] && src_i[i] && !prev_q) |=> stat_q);

            // R4: level mode tracks the sampled source
            p_level_track_r4: assert property (@(posedge clk) disable iff (rst)
                cfg_i.mode_hi[i] |=> (stat_q == $past(src_i[i])));

            // R5: edge-latched bits hold until a read
            p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
                (!cfg_i.mode_hi[i] && stat_q && !clr_i) |=> stat_q);

            // R5: a read with no new edge clears an edge-latched bit
            p_clear_r5: assert property (@(posedge clk) disable iff (rst)
                (!cfg_i.mode_hi[i] && clr_i && !edge_hit) |=> !stat_q);
        end else begin : g_tie
            assign stat_o[i] = 1'b0;
        end
    end

    assign hit_o = |(stat_o & cfg_i.enable);

endmodule

// File: rtl/irq_pin_fmt.sv
module irq_pin_fmt
    import irq_stat_pkg::*;
(
    input  logic       active_i,
    input  pin_style_e style_i,
    output pin_drv_t   drv_o
);

    always_comb begin
        case (style_i)
            PIN_HIGH: drv_o = '{level: active_i,  oe: 1'b1};
            PIN_LOW:  drv_o = '{level: ~active_i, oe: 1'b1};
            default:  drv_o = '{level: 1'b0,      oe: active_i};
        endcase
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_a_i,
    input  logic [REG_W-1:0]  evt_b_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [1:0]        pin_style_i,
    output logic              irq_pin_o,
    output logic              irq_oe_o
);

    bank_cfg_t        cfg_a_q, cfg_b_q;
    logic [REG_W-1:0] stat_a, stat_b;
    logic             hit_a, hit_b, irq_any;
    logic             clr_a, clr_b;
    pin_drv_t         drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a_q <= '0;
            cfg_b_q <= '0;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                ADR_EN_A: cfg_a_q.enable  <= reg_wdata_i & STAT_A_DEFINED;
                ADR_HI_A: cfg_a_q.mode_hi <= reg_wdata_i & STAT_A_DEFINED;
                ADR_LO_A: cfg_a_q.mode_lo <= reg_wdata_i & STAT_A_DEFINED;
                ADR_EN_B: cfg_b_q.enable  <= reg_wdata_i & STAT_B_DEFINED;
                ADR_HI_B: cfg_b_q.mode_hi <= reg_wdata_i & STAT_B_DEFINED;
                ADR_LO_B: cfg_b_q.mode_lo <= reg_wdata_i & STAT_B_DEFINED;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_i)
            ADR_STAT_A: reg_rdata_o = stat_a;
            ADR_STAT_B: reg_rdata_o = stat_b;
            ADR_EN_A:   reg_rdata_o = cfg_a_q.enable;
            ADR_HI_A:   reg_rdata_o = cfg_a_q.mode_hi;
            ADR_LO_A:   reg_rdata_o = cfg_a_q.mode_lo;
            ADR_EN_B:   reg_rdata_o = cfg_b_q.enable;
            ADR_HI_B:   reg_rdata_o = cfg_b_q.mode_hi;
            ADR_LO_B:   reg_rdata_o = cfg_b_q.mode_lo;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign clr_a = reg_rd_i && (reg_addr_i == ADR_STAT_A);
    assign clr_b = reg_rd_i && (reg_addr_i == ADR_STAT_B);

    irq_stat_bank #(.DEFINED(STAT_A_DEFINED)) u_bank_a (
        .clk(clk), .rst(rst), .src_i(evt_a_i), .cfg_i(cfg_a_q),
        .clr_i(clr_a), .stat_o(stat_a), .hit_o(hit_a)
    );

    irq_stat_bank #(.DEFINED(STAT_B_DEFINED)) u_bank_b (
        .clk(clk), .rst(rst), .src_i(evt_b_i), .cfg_i(cfg_b_q),
        .clr_i(clr_b), .stat_o(stat_b), .hit_o(hit_b)
    );

    assign irq_any = hit_a | hit_b;

    irq_pin_fmt u_pin (
        .active_i(irq_any),
        .style_i (pin_style_e'(pin_style_i)),
        .drv_o   (drv)
    );

    assign irq_pin_o = drv.level;
    assign irq_oe_o  = drv.oe;

    // R6: configuration changes only on a write
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_i |=> ($stable(cfg_a_q) && $stable(cfg_b_q)));

    // R7: undefined positions never hold configuration
    p_cfg_defined_r7: assert property (@(posedge clk) disable iff (rst)
        ((cfg_a_q.enable | cfg_a_q.mode_hi | cfg_a_q.mode_lo) & ~STAT_A_DEFINED) == '0 &&
        ((cfg_b_q.enable | cfg_b_q.mode_hi | cfg_b_q.mode_lo) & ~STAT_B_DEFINED) == '0);

    // R9: any enabled pending status bit means an active interrupt
    p_any_active_r9: assert property (@(posedge clk) disable iff (rst)
        (((stat_a & cfg_a_q.enable) | (stat_b & cfg_b_q.enable)) != '0) |-> irq_any);

    // R12: open drain never drives high
    p_od_release_r12: assert property (@(posedge clk) disable iff (rst)
        pin_style_i[1] |-> (!irq_pin_o && (irq_oe_o == irq_any)));

endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] evt_a, evt_b;
    logic [6:0] addr;
    logic       wr, rd;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] style;
    logic       pin, oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_a_i(evt_a), .evt_b_i(evt_b),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .pin_style_i(style), .irq_pin_o(pin), .irq_oe_o(oe)
    );

    // {address, write data, expected readback}
    localparam int NVEC = 10;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h09, 8'hFF, 8'hC7},
        {8'h0A, 8'hFF, 8'hC7},
        {8'h0B, 8'h5A, 8'h42},
        {8'h0C, 8'hFF, 8'h0E},
        {8'h0D, 8'hFF, 8'h0E},
        {8'h0E, 8'h3C, 8'h0C},
        {8'h07, 8'hFF, 8'h00},
        {8'h08, 8'hFF, 8'h00},
        {8'h20, 8'hFF, 8'h00},
        {8'h00, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        evt_a = '0; evt_b = '0; addr = '0; wr = 0; rd = 0; wdata = '0; style = 2'b00;
        do_reset();

        // R6 R7: map and defined bits, table driven
        for (int k = 0; k < NVEC; k++) begin
            wr_reg(VEC[k][22:16], VEC[k][15:8]);
            rd_reg(VEC[k][22:16], v);
            chk("R6/R7 map", v, VEC[k][7:0]);
        end

        do_reset();
        // R1: reset state
        rd_reg(7'h07, v); chk("R1 status A", v, 8'h00);
        rd_reg(7'h09, v); chk("R1 enable A", v, 8'h00);
        rd_reg(7'h0D, v); chk("R1 mode B hi", v, 8'h00);
        #1 chk("R1 pin", {7'b0, pin}, 8'h00);
        chk("R1 oe", {7'b0, oe}, 8'h01);

        // R2 R9 R10: rising edge on bit 0
        wr_reg(7'h09, 8'h01);
        @(negedge clk); evt_a[0] = 1'b1;
        @(negedge clk); #1 chk("R10 pin active", {7'b0, pin}, 8'h01);
        rd_reg(7'h07, v); chk("R2 rise latched", v, 8'h01);
        #1 chk("R9 pin idle after clear", {7'b0, pin}, 8'h00);
        rd_reg(7'h07, v); chk("R2 held high no re-set", v, 8'h00);
        evt_a[0] = 1'b0;

        // R3: falling mode on bit 1
        wr_reg(7'h0B, 8'h02);
        evt_a[1] = 1'b1;
        rd_reg(7'h07, v); chk("R3 rise ignored", v, 8'h00);
        evt_a[1] = 1'b0;
        rd_reg(7'h07, v); chk("R3 fall latched", v, 8'h02);

        // R4: level mode on bit 2
        wr_reg(7'h0A, 8'h04);
        evt_a[2] = 1'b1;
        rd_reg(7'h07, v); chk("R4 level high", v, 8'h04);
        rd_reg(7'h07, v); chk("R4 read does not clear", v, 8'h04);
        evt_a[2] = 1'b0;
        rd_reg(7'h07, v); chk("R4 level follows low", v, 8'h00);

        // R5: edge in the same cycle as the read
        @(negedge clk);
        addr = 7'h07; rd = 1'b1; evt_a[0] = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        rd_reg(7'h07, v); chk("R5 same-cycle edge kept", v, 8'h01);
        evt_a[0] = 1'b0;

        // R7: events on undefined bits
        evt_a = 8'h38;
        rd_reg(7'h07, v); chk("R7 undefined A events", v, 8'h00);
        evt_a = 8'h00;
        evt_b = 8'hF1;
        rd_reg(7'h08, v); chk("R7 undefined B events", v, 8'h00);
        evt_b = 8'h00;

        // R8: blocked bit still latches
        evt_a[7] = 1'b1;
        @(negedge clk); #1 chk("R8 blocked pin", {7'b0, pin}, 8'h00);
        rd_reg(7'h07, v); chk("R8 blocked bit latched", v, 8'h80);
        evt_a[7] = 1'b0;

        // R9: interrupt from register B alone
        wr_reg(7'h0C, 8'h02);
        evt_b[1] = 1'b1;
        @(negedge clk); #1 chk("R9 pin from B", {7'b0, pin}, 8'h01);
        rd_reg(7'h08, v); chk("R9 status B", v, 8'h02);
        #1 chk("R9 pin clears", {7'b0, pin}, 8'h00);
        evt_b[1] = 1'b0;

        // R11 R12: pin styles with interrupt active
        @(negedge clk); evt_b[1] = 1'b1;
        @(negedge clk);
        style = 2'b01; #1 chk("R11 low active pin", {7'b0, pin}, 8'h00);
        chk("R11 oe", {7'b0, oe}, 8'h01);
        style = 2'b10; #1 chk("R12 od active pin", {7'b0, pin}, 8'h00);
        chk("R12 od active oe", {7'b0, oe}, 8'h01);
        style = 2'b11; #1 chk("R12 alt od oe", {7'b0, oe}, 8'h01);
        rd_reg(7'h08, v);
        style = 2'b10; #1 chk("R12 od idle oe", {7'b0, oe}, 8'h00);
        chk("R12 od idle pin", {7'b0, pin}, 8'h00);
        style = 2'b01; #1 chk("R11 low idle pin", {7'b0, pin}, 8'h01);
        style = 2'b00; #1 chk("R10 high idle pin", {7'b0, pin}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule